// File: doc/BRIEF.md
# Next-PC and Control-Flow Resolver

This combinational block decides where a 16-bit processor fetches next. It takes the current program counter, the instruction word being executed, and the value already read from the register named in instruction bits 11:9. From these it produces the next PC, a request to write the return address into link register r7, and strobes that set or clear the privilege bit (bit 15 of the processor status word).

It handles the service-call entry and return, direct and register jumps, calls, and conditional branches. A conditional branch tests the sign of the named register directly; no stored condition codes are used. Every PC-relative target is measured from PC+1. Any opcode that does not transfer control simply advances to PC+1. The register file, the status register and memory sit outside the block. The surrounding pipeline applies the link write only after the target has been read, so a register call through r7 still jumps to the old r7.

Top module: `next_pc_resolver`

## Requirements
- R1: For opcodes 0000, 0001 and 1001 through 1111, nextPc equals pcIn+1, and linkWe, privSet and privClr are all 0.
- R2: For opcode 0100, a direct jump, nextPc equals pcIn+1 plus bits 11:0 sign-extended, and linkWe is 0.
- R3: For opcode 0110, a direct call, nextPc is the same as in R2, linkWe is 1 and linkVal equals pcIn+1.
- R4: For opcode 0101, a register jump, nextPc equals regVal and linkWe is 0.
- R5: For opcode 0111, a register call, nextPc equals regVal as presented at the input, and linkWe is 1 with linkVal equal to pcIn+1.
- R6: For opcode 0010, a service call, nextPc equals bits 7:0 zero-extended, linkWe is 1 and privSet is 1. Bits 11:8 have no effect.
- R7: For opcode 0011, a service return, nextPc equals regVal, privClr is 1, and linkWe and privSet are 0.
- R8: For opcode 1000, bit 8 enables the negative case, bit 7 the zero case and bit 6 the positive case. When the class of regVal matches an enabled bit, nextPc equals pcIn+1 plus bits 5:0 sign-extended. Otherwise nextPc equals pcIn+1. A branch never writes the link.
- R9: A branch mask of 000 never branches, for any regVal. A mask of 111 always branches.
- R10: regVal is negative when bit 15 is 1, zero when all bits are 0, and positive otherwise.
- R11: All address arithmetic wraps modulo 2^16. For example, pcIn=FFFF with a non-control opcode gives nextPc=0000.
- R12: privSet and privClr are never 1 together, and whenever linkWe is 1, linkVal equals pcIn+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pcIn | input | 16 | Address of the current instruction |
| instr | input | 16 | Current instruction word |
| regVal | input | 16 | Value of the register named in instr[11:9] |
| nextPc | output | 16 | Address of the next instruction |
| linkWe | output | 1 | Request to write linkVal into r7 |
| linkVal | output | 16 | Return address, pcIn+1 |
| privSet | output | 1 | Set the privilege bit |
| privClr | output | 1 | Clear the privilege bit |

## Verification
The assertions assume that the three inputs are fully known whenever they are evaluated. They also assume that regVal is the register value before any link write from the same instruction, so a register call through r7 sees the old r7. The bench drives only defined values and supplies regVal as an independent input, so this order always holds. Random opcodes are weighted toward the control-transfer codes. Register values are drawn from a set of sign-class corners (0, 0001, 7FFF, 8000, FFFF) as well as from plain random words, so every mask bit meets every class.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int WORD_W      = 16;
  localparam int OPC_W       = 4;
  localparam int OPC_LSB     = WORD_W - OPC_W;
  localparam int REL_LONG_W  = 12;
  localparam int REL_SHORT_W = 6;
  localparam int VEC_W       = 8;
  localparam int MASK_W      = 3;
  localparam int MASK_LSB    = REL_SHORT_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OPC_W-1:0]  opc_t;

  localparam opc_t OPC_SVC_CALL = 4'h2;
  localparam opc_t OPC_SVC_RET  = 4'h3;
  localparam opc_t OPC_JMP_REL  = 4'h4;
  localparam opc_t OPC_JMP_REG  = 4'h5;
  localparam opc_t OPC_CALL_REL = 4'h6;
  localparam opc_t OPC_CALL_REG = 4'h7;
  localparam opc_t OPC_BRANCH   = 4'h8;

  typedef enum logic [2:0] {
    TGT_SEQ,
    TGT_LONG,
    TGT_SHORT,
    TGT_REG,
    TGT_VEC
  } tgtSel_e;

  typedef struct packed {
    tgtSel_e tgtSel;
    logic    linkWe;
    logic    privSet;
    logic    privClr;
  } cfStrobes_t;

  typedef struct packed {
    logic isNeg;
    logic isZero;
    logic isPos;
  } signClass_t;
endpackage

// File: rtl/cf_sign_class.sv
module cf_sign_class
  import cf_pkg::*;
(
  input  word_t      value,
  output signClass_t sClass
);
  logic msb;
  logic allZero;

  assign msb     = value[WORD_W-1];
  assign allZero = (value == '0);

  always_comb begin
    sClass.isNeg  = msb;
    sClass.isZero = allZero;
    sClass.isPos  = !msb && !allZero;
  end
endmodule

// File: rtl/cf_control.sv
module cf_control
  import cf_pkg::*;
(
  input  opc_t              opcode,
  input  logic [MASK_W-1:0] condMask,
  input  signClass_t        sClass,
  output cfStrobes_t        strobes
);
  logic [MASK_W-1:0] classVec;
  logic              condHit;

  // mask order: high bit negative, middle zero, low positive
  assign classVec = {sClass.isNeg, sClass.isZero, sClass.isPos};
  assign condHit  = |(condMask & classVec);

  always_comb begin
    strobes = '{tgtSel: TGT_SEQ, linkWe: 1'b0, privSet: 1'b0, privClr: 1'b0};
    unique case (opcode)
      OPC_SVC_CALL: begin
        strobes.tgtSel  = TGT_VEC;
        strobes.linkWe  = 1'b1;
        strobes.privSet = 1'b1;
      end
      OPC_SVC_RET: begin
        strobes.tgtSel  = TGT_REG;
        strobes.privClr = 1'b1;
      end
      OPC_JMP_REL:  strobes.tgtSel = TGT_LONG;
      OPC_JMP_REG:  strobes.tgtSel = TGT_REG;
      OPC_CALL_REL: begin
        strobes.tgtSel = TGT_LONG;
        strobes.linkWe = 1'b1;
      end
      OPC_CALL_REG: begin
        strobes.tgtSel = TGT_REG;
        strobes.linkWe = 1'b1;
      end
      OPC_BRANCH:   strobes.tgtSel = condHit ? TGT_SHORT : TGT_SEQ;
      default:      strobes.tgtSel = TGT_SEQ;
    endcase
  end
endmodule

// File: rtl/cf_datapath.sv
module cf_datapath
  import cf_pkg::*;
(
  input  word_t      pcIn,
  input  word_t      instr,
  input  word_t      regVal,
  input  cfStrobes_t strobes,
  output word_t      nextPc,
  output word_t      linkVal
);
  word_t seqPc;
  word_t longOff;
  word_t shortOff;
  word_t vecAddr;
  word_t longTgt;
  word_t shortTgt;

  assign seqPc    = pcIn + word_t'(1);
  assign longOff  = {{(WORD_W-REL_LONG_W){instr[REL_LONG_W-1]}},  instr[REL_LONG_W-1:0]};
  assign shortOff = {{(WORD_W-REL_SHORT_W){instr[REL_SHORT_W-1]}}, instr[REL_SHORT_W-1:0]};
  assign vecAddr  = {{(WORD_W-VEC_W){1'b0}}, instr[VEC_W-1:0]};
  assign longTgt  = seqPc + longOff;
  assign shortTgt = seqPc + shortOff;

  always_comb begin
    unique case (strobes.tgtSel)
      TGT_LONG:  nextPc = longTgt;
      TGT_SHORT: nextPc = shortTgt;
      TGT_REG:   nextPc = regVal;
      TGT_VEC:   nextPc = vecAddr;
      default:   nextPc = seqPc;
    endcase
  end

  assign linkVal = seqPc;
endmodule

// File: rtl/next_pc_resolver.sv
module next_pc_resolver
  import cf_pkg::*;
(
  input  logic [15:0] pcIn,
  input  logic [15:0] instr,
  input  logic [15:0] regVal,
  output logic [15:0] nextPc,
  output logic        linkWe,
  output logic [15:0] linkVal,
  output logic        privSet,
  output logic        privClr
);
  signClass_t sClass;
  cfStrobes_t strobes;

  cf_sign_class u_sign (
    .value  (regVal),
    .sClass (sClass)
  );

  cf_control u_ctrl (
    .opcode   (instr[WORD_W-1:OPC_LSB]),
    .condMask (instr[MASK_LSB+MASK_W-1:MASK_LSB]),
    .sClass   (sClass),
    .strobes  (strobes)
  );

  cf_datapath u_dp (
    .pcIn    (pcIn),
    .instr   (instr),
    .regVal  (regVal),
    .strobes (strobes),
    .nextPc  (nextPc),
    .linkVal (linkVal)
  );

  assign linkWe  = strobes.linkWe;
  assign privSet = strobes.privSet;
  assign privClr = strobes.privClr;
endmodule

// File: rtl/next_pc_resolver_checker.sv
module next_pc_resolver_checker (
  input logic [15:0] pcIn,
  input logic [15:0] instr,
  input logic [15:0] regVal,
  input logic [15:0] nextPc,
  input logic        linkWe,
  input logic [15:0] linkVal,
  input logic        privSet,
  input logic        privClr
);
  logic [3:0]  opc;
  logic [15:0] seq;
  logic        known;

  assign opc   = instr[15:12];
  assign seq   = pcIn + 16'd1;
  assign known = !$isunknown({pcIn, instr, regVal});

  always_comb begin
    if (known) begin
      p_strobe_excl_r12: assert (!(privSet && privClr))
        else $error("privSet and privClr both high");
      if (linkWe) begin
        p_link_val_r12: assert (linkVal == seq)
          else $error("link value is not pc+1");
      end
      if (opc == 4'h0 || opc == 4'h1 || opc >= 4'h9) begin
        p_seq_r1: assert (nextPc == seq && !linkWe && !privSet && !privClr)
          else $error("non-control opcode disturbed flow");
      end
      if (opc == 4'h2) begin
        p_svc_call_r6: assert (nextPc[15:8] == 8'h00 && linkWe && privSet)
          else $error("service call outputs wrong");
      end
      if (opc == 4'h3) begin
        p_svc_ret_r7: assert (nextPc == regVal && privClr && !linkWe)
          else $error("service return outputs wrong");
      end
      if (opc == 4'h7) begin
        p_call_reg_r5: assert (nextPc == regVal && linkWe)
          else $error("register call outputs wrong");
      end
      if (opc == 4'h8 && instr[8:6] == 3'b000) begin
        p_noop_mask_r9: assert (nextPc == seq && !linkWe)
          else $error("empty mask branched");
      end
    end
  end
endmodule

bind next_pc_resolver next_pc_resolver_checker u_chk (.*);

// File: tb/next_pc_resolver_bench.sv
module next_pc_resolver_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pcIn = '0;
  logic [15:0] instr = '0;
  logic [15:0] regVal = '0;
  logic [15:0] nextPc;
  logic        linkWe;
  logic [15:0] linkVal;
  logic        privSet;
  logic        privClr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  next_pc_resolver u_next_pc_resolver (
    .pcIn(pcIn), .instr(instr), .regVal(regVal),
    .nextPc(nextPc), .linkWe(linkWe), .linkVal(linkVal),
    .privSet(privSet), .privClr(privClr)
  );

  function automatic logic [15:0] sx(input logic [15:0] v, input int w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  function automatic logic [18:0] refModel(input logic [15:0] pc, input logic [15:0] ins,
                                            input logic [15:0] rv);
    logic [15:0] np;
    logic lw, ps, pc_;
    logic [15:0] nxt;
    bit neg, zer, pos, hit;
    nxt = pc + 16'd1;
    np = nxt; lw = 0; ps = 0; pc_ = 0;
    neg = rv[15]; zer = (rv == 0); pos = !neg && !zer;
    case (ins[15:12])
      4'h2: begin np = {8'h00, ins[7:0]}; lw = 1; ps = 1; end
      4'h3: begin np = rv; pc_ = 1; end
      4'h4: np = nxt + sx(ins, 12);
      4'h5: np = rv;
      4'h6: begin np = nxt + sx(ins, 12); lw = 1; end
      4'h7: begin np = rv; lw = 1; end
      4'h8: begin
        hit = (ins[8] && neg) || (ins[7] && zer) || (ins[6] && pos);
        if (hit) np = nxt + sx(ins, 6);
      end
      default: ;
    endcase
    return {np, lw, ps, pc_};
  endfunction

  function automatic string tagOf(input logic [15:0] ins);
    case (ins[15:12])
      4'h2: return "R6";
      4'h3: return "R7";
      4'h4: return "R2";
      4'h5: return "R4";
      4'h6: return "R3";
      4'h7: return "R5";
      4'h8: return (ins[8:6] == 3'b000 || ins[8:6] == 3'b111) ? "R9" : "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic applyCheck(input logic [15:0] pc, input logic [15:0] ins,
                            input logic [15:0] rv, input string tag);
    logic [18:0] e;
    @(posedge clk);
    pcIn = pc; instr = ins; regVal = rv;
    @(negedge clk);
    e = refModel(pc, ins, rv);
    testsRun++;
    if (nextPc !== e[18:3] || linkWe !== e[2] || privSet !== e[1] || privClr !== e[0]) begin
      testsFailed++;
      $display("FAIL %s: pc=%h ins=%h rv=%h got np=%h lw=%b ps=%b pc=%b exp np=%h lw=%b ps=%b pc=%b",
               tag, pc, ins, rv, nextPc, linkWe, privSet, privClr, e[18:3], e[2], e[1], e[0]);
    end
    if (linkWe === 1'b1) begin
      testsRun++;
      if (linkVal !== pc + 16'd1) begin
        testsFailed++;
        $display("FAIL R12: linkVal got %h exp %h", linkVal, pc + 16'd1);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] corners [5];
    logic [15:0] ins, rv;
    logic [3:0] op;
    corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'h7FFF;
    corners[3] = 16'h8000; corners[4] = 16'hFFFF;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state inputs are all zero: sequential flow (R1)
    applyCheck(16'h0000, 16'h0000, 16'h0000, "R1");
    // wraparound (R11)
    applyCheck(16'hFFFF, 16'h9123, 16'h0000, "R11");
    applyCheck(16'hFFFF, 16'h4000, 16'h0000, "R11");
    applyCheck(16'h0000, 16'h4FFE, 16'h0000, "R11");
    // long offsets (R2, R3)
    applyCheck(16'h1000, 16'h47FF, 16'h0000, "R2");
    applyCheck(16'h1000, 16'h6800, 16'h0000, "R3");
    // register transfer with r7 target read before link (R4, R5)
    applyCheck(16'h2000, 16'h5E00, 16'hBEEF, "R4");
    applyCheck(16'h2000, 16'h7E00, 16'h1234, "R5");
    // service call, bits 11:8 ignored (R6), service return (R7)
    applyCheck(16'h3000, 16'h2025, 16'h0000, "R6");
    applyCheck(16'h3000, 16'h2F25, 16'hFFFF, "R6");
    applyCheck(16'h0025, 16'h3E00, 16'h3001, "R7");
    // branch mask vs every sign class (R8, R9, R10)
    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 5; c++)
        applyCheck(16'h4000, {4'h8, 3'd1, m[2:0], 6'h3F}, corners[c],
                   (m == 0 || m == 7) ? "R9" : "R10");
    // random mix (R1..R8)
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      op = ($urandom % 4 == 0) ? 4'($urandom) : 4'(2 + $urandom % 7);
      ins = {op, 12'($urandom)};
      rv = ($urandom % 2 == 0) ? corners[$urandom % 5] : 16'($urandom);
      applyCheck(16'($urandom), ins, rv, tagOf(ins));
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule